// File: doc/BRIEF.md
# Nibble-Addressed Register Steering Decoder

This block sits behind a serial write port that delivers one 4-bit address and one 4-bit data nibble per transaction. The address selects where the nibble goes. Wide registers are assembled a nibble at a time: four addresses fill a 16-bit holding word, and two more addresses plus a shared pointer build a 10-bit memory address. The low nibble of that address also serves as the calibration address. Further addresses load a command nibble, an analog timeout nibble and an analog location nibble. A command load also raises a single-cycle valid pulse toward the internal logic.

One address carries a special key. When the data is all ones, the block requests a relearn of the serial baud rate instead of storing anything. An 8-bit control-location field arrives from configuration storage. When that field holds the lock value 0xFF, the block seals itself. It ignores every later write until reset and tells the output stage to take its signal from the amplifier path.

The reset input is asynchronous and active low. Its release is synchronised internally over two clock edges.

Top module: `nibble_reg_steer`

## Requirements
- R1: After reset all stored nibbles, `hold_o`, `mem_addr_o`, `cmd_valid_o`, `relearn_o`, `lock_o` and `route_amp_o` read zero.
- R2: A write to address 0x0, 0x1, 0x2 or 0x3 stores the nibble in `hold_o` bits [3:0], [7:4], [11:8] or [15:12] respectively, leaving the other bits of `hold_o` unchanged; visible one cycle after the write.
- R3: Address 0x6 loads `mem_addr_o[3:0]` (also presented as `cal_addr_o`); address 0x7 loads `mem_addr_o[7:4]`.
- R4: Address 0x8 loads `set_ptr_o`, and `mem_addr_o[9:8]` always equals `set_ptr_o[1:0]`.
- R5: Addresses 0x9, 0xA and 0xB load `cmd_o`, `tmo_o` and `loc_o` respectively.
- R6: In the cycle after an accepted write to address 0x9, `cmd_valid_o` is high; it is low in every other cycle.
- R7: In the cycle after an accepted write of data 0xF to address 0xF, `relearn_o` is high; that write changes no stored value.
- R8: Writes to addresses 0x4, 0x5, 0xC, 0xD, 0xE, and writes to 0xF with data other than 0xF, change no output and raise no pulse.
- R9: With `wr_en` low, no output changes and no pulse is raised.
- R10: When `ctrl_loc` equals 0xFF at a clock edge, `lock_o` and `route_amp_o` are high from the next cycle and stay high until reset, whatever `ctrl_loc` does afterward.
- R11: A write presented while `lock_o` is high, or in the same cycle that `ctrl_loc` equals 0xFF, is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write transaction strobe |
| wr_addr | input | 4 | Register-set address of the write |
| wr_data | input | 4 | Data nibble of the write |
| ctrl_loc | input | 8 | Control-location field; 0xFF engages the lock |
| hold_o | output | 16 | Assembled holding word |
| mem_addr_o | output | 10 | Internal memory address |
| cal_addr_o | output | 4 | Calibration address (low memory-address nibble) |
| set_ptr_o | output | 4 | Register-set pointer |
| cmd_o | output | 4 | Command nibble for internal logic |
| cmd_valid_o | output | 1 | One-cycle pulse after a command load |
| tmo_o | output | 4 | Analog timeout value |
| loc_o | output | 4 | Analog location |
| relearn_o | output | 1 | One-cycle baud-rate relearn request |
| lock_o | output | 1 | Secure-lock engaged |
| route_amp_o | output | 1 | Output routed to amplifier path (follows the lock) |

## Verification
Two events can land in the same cycle: a write and the first appearance of the lock value on `ctrl_loc`. The bench provokes this by presenting a command write together with `ctrl_loc` = 0xFF. It then expects no `cmd_valid_o` pulse, no change to `cmd_o`, and `lock_o` high on the following cycle. Random traffic interleaves back-to-back command loads, relearn keys and reserved codes, so pulses on consecutive cycles are also compared against the bench's model.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  localparam int NIB_W   = 4;
  localparam int NFIELD  = 10;
  localparam int HOLD_N  = 4;
  localparam int PTR_MB  = 2;   // pointer bits reused as top memory-address bits

  // field slots
  localparam int F_ALO = 4;
  localparam int F_AHI = 5;
  localparam int F_PTR = 6;
  localparam int F_CMD = 7;
  localparam int F_TMO = 8;
  localparam int F_LOC = 9;

  // address codes
  localparam logic [3:0] A_H0  = 4'h0;
  localparam logic [3:0] A_H1  = 4'h1;
  localparam logic [3:0] A_H2  = 4'h2;
  localparam logic [3:0] A_H3  = 4'h3;
  localparam logic [3:0] A_ALO = 4'h6;
  localparam logic [3:0] A_AHI = 4'h7;
  localparam logic [3:0] A_PTR = 4'h8;
  localparam logic [3:0] A_CMD = 4'h9;
  localparam logic [3:0] A_TMO = 4'hA;
  localparam logic [3:0] A_LOC = 4'hB;
  localparam logic [3:0] A_KEY = 4'hF;
  localparam logic [3:0] D_KEY = 4'hF;
endpackage

// File: rtl/nrs_field.sv
module nrs_field #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (en) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/nrs_decode.sv
module nrs_decode
  import nrs_pkg::*;
(
  input  logic              wr_en,
  input  logic              allow,
  input  logic [3:0]        addr,
  input  logic [NIB_W-1:0]  data,
  output logic [NFIELD-1:0] strobe,
  output logic              relearn
);
  always_comb begin
    strobe  = '0;
    relearn = 1'b0;
    if (wr_en && allow) begin
      case (addr)
        A_H0:    strobe[0]     = 1'b1;
        A_H1:    strobe[1]     = 1'b1;
        A_H2:    strobe[2]     = 1'b1;
        A_H3:    strobe[3]     = 1'b1;
        A_ALO:   strobe[F_ALO] = 1'b1;
        A_AHI:   strobe[F_AHI] = 1'b1;
        A_PTR:   strobe[F_PTR] = 1'b1;
        A_CMD:   strobe[F_CMD] = 1'b1;
        A_TMO:   strobe[F_TMO] = 1'b1;
        A_LOC:   strobe[F_LOC] = 1'b1;
        A_KEY:   relearn       = (data == D_KEY);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nrs_lock.sv
module nrs_lock #(
  parameter int              CL_W = 8,
  parameter logic [CL_W-1:0] KEY  = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CL_W-1:0] ctrl_loc,
  output logic            locked,
  output logic            allow
);
  logic hit, locked_nx;

  always_comb begin
    hit       = (ctrl_loc == KEY);
    locked_nx = locked | hit;
    allow     = !locked && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b0;
    else        locked <= locked_nx;
  end
endmodule

// File: rtl/nibble_reg_steer.sv
module nibble_reg_steer
  import nrs_pkg::*;
#(
  parameter int              CL_W     = 8,
  parameter logic [CL_W-1:0] LOCK_KEY = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [3:0]                wr_addr,
  input  logic [NIB_W-1:0]          wr_data,
  input  logic [CL_W-1:0]           ctrl_loc,
  output logic [HOLD_N*NIB_W-1:0]   hold_o,
  output logic [2*NIB_W+PTR_MB-1:0] mem_addr_o,
  output logic [NIB_W-1:0]          cal_addr_o,
  output logic [NIB_W-1:0]          set_ptr_o,
  output logic [NIB_W-1:0]          cmd_o,
  output logic                      cmd_valid_o,
  output logic [NIB_W-1:0]          tmo_o,
  output logic [NIB_W-1:0]          loc_o,
  output logic                      relearn_o,
  output logic                      lock_o,
  output logic                      route_amp_o
);
  // reset release synchroniser
  logic rs1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1        <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1        <= 1'b1;
      rst_sync_n <= rs1;
    end
  end

  logic              allow, relearn_d;
  logic [NFIELD-1:0] strobe;
  logic [NIB_W-1:0]  fq [NFIELD];

  nrs_lock #(.CL_W(CL_W), .KEY(LOCK_KEY)) u_lock (
    .clk(clk), .rst_n(rst_sync_n), .ctrl_loc(ctrl_loc),
    .locked(lock_o), .allow(allow)
  );

  nrs_decode u_dec (
    .wr_en(wr_en), .allow(allow), .addr(wr_addr), .data(wr_data),
    .strobe(strobe), .relearn(relearn_d)
  );

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    nrs_field #(.W(NIB_W)) u_f (
      .clk(clk), .rst_n(rst_sync_n), .en(strobe[g]), .d(wr_data), .q(fq[g])
    );
  end

  for (genvar h = 0; h < HOLD_N; h++) begin : g_hold
    assign hold_o[h*NIB_W +: NIB_W] = fq[h];
  end

  // pulse outputs
  logic cmd_valid_nx, relearn_nx;
  always_comb begin
    cmd_valid_nx = strobe[F_CMD];
    relearn_nx   = relearn_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_valid_o <= 1'b0;
      relearn_o   <= 1'b0;
    end else begin
      cmd_valid_o <= cmd_valid_nx;
      relearn_o   <= relearn_nx;
    end
  end

  assign mem_addr_o  = {fq[F_PTR][PTR_MB-1:0], fq[F_AHI], fq[F_ALO]};
  assign cal_addr_o  = fq[F_ALO];
  assign set_ptr_o   = fq[F_PTR];
  assign cmd_o       = fq[F_CMD];
  assign tmo_o       = fq[F_TMO];
  assign loc_o       = fq[F_LOC];
  assign route_amp_o = lock_o;
endmodule

// File: rtl/nrs_chk.sv
module nrs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [3:0]  wr_data,
  input logic [7:0]  ctrl_loc,
  input logic [15:0] hold_o,
  input logic [9:0]  mem_addr_o,
  input logic [3:0]  set_ptr_o,
  input logic [3:0]  cmd_o,
  input logic        cmd_valid_o,
  input logic [3:0]  tmo_o,
  input logic [3:0]  loc_o,
  input logic        relearn_o,
  input logic        lock_o
);
  logic open_c, rsv_c;
  logic [35:0] st;
  assign open_c = !lock_o && (ctrl_loc != 8'hFF);
  assign rsv_c  = (wr_addr == 4'h4) || (wr_addr == 4'h5) ||
                  (wr_addr == 4'hC) || (wr_addr == 4'hD) || (wr_addr == 4'hE) ||
                  ((wr_addr == 4'hF) && (wr_data != 4'hF));
  assign st = {hold_o, mem_addr_o[7:0], set_ptr_o, cmd_o, tmo_o, loc_o} ;

  assert_cmd_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(wr_en && wr_addr == 4'h9 && open_c));
  assert_cmd_pulse_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'h9 && open_c) |=> cmd_valid_o);
  assert_relearn_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    relearn_o |-> $past(wr_en && wr_addr == 4'hF && wr_data == 4'hF && open_c));
  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rsv_c) |=> ($stable(st) && !cmd_valid_o && !relearn_o));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(st) && !cmd_valid_o && !relearn_o));
  assert_lock_engage_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_loc == 8'hFF) |=> lock_o);
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> lock_o);
  assert_lock_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !open_c |=> ($stable(st) && $stable(mem_addr_o) && !cmd_valid_o && !relearn_o));
endmodule

bind nibble_reg_steer nrs_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ctrl_loc(ctrl_loc), .hold_o(hold_o),
  .mem_addr_o(mem_addr_o), .set_ptr_o(set_ptr_o), .cmd_o(cmd_o),
  .cmd_valid_o(cmd_valid_o), .tmo_o(tmo_o), .loc_o(loc_o),
  .relearn_o(relearn_o), .lock_o(lock_o)
);

// File: tb/nibble_reg_steer_test.sv
module nibble_reg_steer_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, wr_data = '0;
  logic [7:0] ctrl_loc = '0;
  logic [15:0] hold_o;
  logic [9:0]  mem_addr_o;
  logic [3:0]  cal_addr_o, set_ptr_o, cmd_o, tmo_o, loc_o;
  logic cmd_valid_o, relearn_o, lock_o, route_amp_o;

  always #(CLK_P/2) clk = ~clk;

  nibble_reg_steer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_loc(ctrl_loc), .hold_o(hold_o),
    .mem_addr_o(mem_addr_o), .cal_addr_o(cal_addr_o), .set_ptr_o(set_ptr_o),
    .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .tmo_o(tmo_o), .loc_o(loc_o),
    .relearn_o(relearn_o), .lock_o(lock_o), .route_amp_o(route_amp_o)
  );

  int checks = 0, fails = 0;
  string ctx = "";

  logic [15:0] m_hold;
  logic [3:0]  m_alo, m_ahi, m_ptr, m_cmd, m_tmo, m_loc;
  logic        m_cv, m_rl, m_lock;

  function automatic logic [15:0] put_nib(logic [15:0] w, logic [1:0] i, logic [3:0] d);
    logic [15:0] r = w;
    r[i*4 +: 4] = d;
    return r;
  endfunction

  function automatic logic [9:0] exp_maddr(logic [3:0] p, logic [3:0] hi, logic [3:0] lo);
    return {p[1:0], hi, lo};
  endfunction

  task automatic model_clear();
    m_hold = '0; m_alo = '0; m_ahi = '0; m_ptr = '0; m_cmd = '0;
    m_tmo = '0; m_loc = '0; m_cv = 1'b0; m_rl = 1'b0; m_lock = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", ctx, tag, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 hold", hold_o, m_hold);
    chk("R3 mem_addr", {6'd0, mem_addr_o}, {6'd0, exp_maddr(m_ptr, m_ahi, m_alo)});
    chk("R3 cal_addr", {12'd0, cal_addr_o}, {12'd0, m_alo});
    chk("R4 set_ptr", {12'd0, set_ptr_o}, {12'd0, m_ptr});
    chk("R5 cmd/tmo/loc", {4'd0, cmd_o, tmo_o, loc_o}, {4'd0, m_cmd, m_tmo, m_loc});
    chk("R6 cmd_valid", {15'd0, cmd_valid_o}, {15'd0, m_cv});
    chk("R7 relearn", {15'd0, relearn_o}, {15'd0, m_rl});
    chk("R10 lock/route", {14'd0, lock_o, route_amp_o}, {14'd0, m_lock, m_lock});
  endtask

  // compare results of the previous cycle, then present new inputs
  task automatic step(input logic en, input logic [3:0] a, input logic [3:0] d,
                      input logic [7:0] cl);
    logic blk;
    @(negedge clk);
    compare_all();
    wr_en = en; wr_addr = a; wr_data = d; ctrl_loc = cl;
    blk  = m_lock || (cl == 8'hFF);
    m_cv = 1'b0;
    m_rl = 1'b0;
    if (en && !blk) begin
      case (a)
        4'h0, 4'h1, 4'h2, 4'h3: m_hold = put_nib(m_hold, a[1:0], d);
        4'h6: m_alo = d;
        4'h7: m_ahi = d;
        4'h8: m_ptr = d;
        4'h9: begin m_cmd = d; m_cv = 1'b1; end
        4'hA: m_tmo = d;
        4'hB: m_loc = d;
        4'hF: m_rl = (d == 4'hF);
        default: ;
      endcase
    end
    if (cl == 8'hFF) m_lock = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; ctrl_loc = '0;
    repeat (2) @(negedge clk);
    model_clear();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ctx = "R1 reset";
    compare_all();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1455));
    model_clear();
    do_reset();

    ctx = "R2 directed";
    step(1, 4'h0, 4'hA, 8'h00);
    step(1, 4'h3, 4'h5, 8'h00);
    step(1, 4'h1, 4'hC, 8'h00);
    step(1, 4'h2, 4'h7, 8'h00);

    ctx = "R3 R4 directed";
    step(1, 4'h6, 4'h9, 8'h00);
    step(1, 4'h7, 4'hE, 8'h00);
    step(1, 4'h8, 4'hB, 8'h00);

    ctx = "R5 R6 directed back-to-back";
    step(1, 4'h9, 4'h3, 8'h00);
    step(1, 4'h9, 4'h6, 8'h00);
    step(1, 4'hA, 4'h1, 8'h00);
    step(1, 4'hB, 4'h2, 8'h00);

    ctx = "R7 directed";
    step(1, 4'hF, 4'hF, 8'h00);
    step(0, 4'hF, 4'hF, 8'h00);

    ctx = "R8 reserved";
    step(1, 4'h4, 4'h1, 8'h00);
    step(1, 4'h5, 4'h2, 8'h00);
    step(1, 4'hC, 4'h3, 8'h00);
    step(1, 4'hD, 4'h4, 8'h00);
    step(1, 4'hE, 4'h5, 8'h00);
    for (int k = 0; k < 15; k++) step(1, 4'hF, k[3:0], 8'h00);

    ctx = "R9 idle";
    for (int k = 0; k < 16; k++) step(0, k[3:0], 4'hF - k[3:0], 8'hFE);

    ctx = "random";
    for (int k = 0; k < 1500; k++) begin
      logic [3:0] a, d;
      logic en;
      en = ($urandom % 4) != 0;
      a  = 4'($urandom);
      d  = ($urandom % 3 == 0) ? 4'hF : 4'($urandom);
      step(en, a, d, 8'($urandom % 255));
    end

    ctx = "R11 lock with write in same cycle";
    step(1, 4'h9, ~m_cmd, 8'hFF);
    ctx = "R11 R10 locked";
    step(1, 4'h0, ~m_hold[3:0], 8'h00);
    step(1, 4'hF, 4'hF, 8'h12);
    step(1, 4'h9, ~m_cmd, 8'h00);
    for (int k = 0; k < 20; k++) step(1, 4'($urandom), 4'($urandom), 8'($urandom));
    step(0, 4'h0, 4'h0, 8'h00);

    do_reset();
    ctx = "R1 after reset write";
    step(1, 4'h9, 4'h4, 8'h00);
    step(0, 4'h0, 4'h0, 8'h00);
    step(0, 4'h0, 4'h0, 8'h00);

    finish_run();
  end
endmodule